// File: doc/BRIEF.md
# Errored Second Alarm Monitor

This block collects receive-side alarm and error indications over each one-second interval. An internal timer divides a reference clock enable down to a one-cycle tick that marks the end of each interval. During the interval, every source that fires is recorded in a sticky flag. At the tick, an errored-second interrupt status bit is raised if any source allowed by the host mask was recorded, and the flags restart for the new second.

The tick also raises its own one-second interrupt status bit, which tells the host to inspect the status bits and error counters. It is also driven on a pin in a form that a configuration field selects. Both status bits clear when the host reads them. A shared interrupt line stays asserted while either bit is set. The alarm detectors and the host bus lie outside the block. All pins are plain control and status signals. No data stream passes through, so there is no valid/ready handshake.

Top module: `es_monitor`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, isr_es, isr_sec, irq and flags are 0. With pin_mode 1, sec_out is also 0.
- R2: The timer counts cycles in which ref_ce is 1. The cycle after the enabled cycle that finds the count at or above tick_limit, it produces an internal tick that lasts one cycle. The count then restarts from 0, so with ref_ce held high a tick occurs every tick_limit+1 cycles. A cycle with ref_ce low leaves the count unchanged.
- R3: The source order on evt_in and es_mask is: bit 0 framing error, bit 1 CRC error, bit 2 code violation, bit 3 loss of frame alignment, bit 4 loss of signal, bit 5 alarm indication signal, bit 6 receive slip, bit 7 transmit slip. A flag sets when its evt_in bit is 1 and holds until the tick. In the tick cycle the flags are replaced by that cycle's evt_in, so an event in the tick cycle counts toward the new second.
- R4: In a tick cycle, isr_es is set in the next cycle if the flags ANDed with es_mask are nonzero. A source whose mask bit is 0 never causes isr_es.
- R5: isr_sec is set in the cycle after every tick.
- R6: sec_out follows pin_mode. Mode 0 drives 0. Mode 1 drives a high pulse during the tick cycle. Mode 2 drives a low pulse during the tick cycle. Mode 3 drives a level that inverts in the cycle after each tick and starts at 0 after reset.
- R7: When stat_rd is 1 in a cycle, both status bits are cleared in the next cycle, unless that cycle is a tick that sets them again. A set that coincides with a read is not lost.
- R8: irq is 1 exactly when isr_es or isr_sec is 1.
- R9: A level alarm that is held across a second boundary counts as an event in both seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ce | input | 1 | Reference clock enable counted by the timer |
| tick_limit | input | CNT_W | Terminal count of the timer |
| evt_in | input | 8 | Event pulses and alarm levels, one per source |
| es_mask | input | 8 | Per-source enable for the errored-second interrupt |
| pin_mode | input | 2 | Form of the one-second signal on sec_out |
| stat_rd | input | 1 | Host read strobe; clears the status bits |
| isr_es | output | 1 | Errored-second interrupt status |
| isr_sec | output | 1 | One-second timer interrupt status |
| irq | output | 1 | Interrupt request, any status bit set |
| sec_out | output | 1 | One-second signal pin |
| flags | output | 8 | Sticky event flags of the current second |

## Verification
A wrong timer count moves isr_sec and the sec_out pulse away from the expected cycle. This shows within one interval of tick_limit+1 enabled cycles. A corrupted or stuck flag shows at once on the flags port. At the next tick it also shows as a wrong isr_es, while a masked flag must show no effect on isr_es at all. A lost or late status set or clear shows on isr_es, isr_sec and irq in the cycle after the tick or the read.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int NSRC = 8;

  localparam int SRC_FRAME = 0;
  localparam int SRC_CRC   = 1;
  localparam int SRC_CODE  = 2;
  localparam int SRC_LOFA  = 3;
  localparam int SRC_LOSIG = 4;
  localparam int SRC_AIS   = 5;
  localparam int SRC_RSLIP = 6;
  localparam int SRC_TSLIP = 7;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_PULSE  = 2'd1,
    PIN_NPULSE = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/es_sec_timer.sv
module es_sec_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ce,
  input  logic [CNT_W-1:0] tick_limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = ref_ce && (cnt >= tick_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= at_end;
      if (at_end)      cnt <= '0;
      else if (ref_ce) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/es_event_latch.sv
module es_event_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] evt_in,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)    flags[i] <= 1'b0;
      else if (tick) flags[i] <= evt_in[i];
      else           flags[i] <= flags[i] | evt_in[i];
    end
  end
endmodule

// File: rtl/es_status.sv
module es_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] es_mask,
  input  logic         stat_rd,
  input  logic [1:0]   pin_mode,
  output logic         isr_es,
  output logic         isr_sec,
  output logic         irq,
  output logic         sec_out
);
  import es_pkg::*;

  logic es_hit;
  logic tog;

  assign es_hit = |(flags & es_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_es  <= 1'b0;
      isr_sec <= 1'b0;
      tog     <= 1'b0;
    end else begin
      isr_es  <= (isr_es  & ~stat_rd) | (tick & es_hit);
      isr_sec <= (isr_sec & ~stat_rd) | tick;
      if (tick) tog <= ~tog;
    end
  end

  assign irq = isr_es | isr_sec;

  always_comb begin
    case (pin_mode_e'(pin_mode))
      PIN_PULSE:  sec_out = tick;
      PIN_NPULSE: sec_out = ~tick;
      PIN_TOGGLE: sec_out = tog;
      default:    sec_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/es_monitor.sv
module es_monitor #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_ce,
  input  logic [CNT_W-1:0]        tick_limit,
  input  logic [es_pkg::NSRC-1:0] evt_in,
  input  logic [es_pkg::NSRC-1:0] es_mask,
  input  logic [1:0]              pin_mode,
  input  logic                    stat_rd,
  output logic                    isr_es,
  output logic                    isr_sec,
  output logic                    irq,
  output logic                    sec_out,
  output logic [es_pkg::NSRC-1:0] flags
);
  localparam int N = es_pkg::NSRC;

  logic tick;

  es_sec_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce),
    .tick_limit(tick_limit), .tick(tick)
  );

  es_event_latch #(.N(N)) u_latch (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .evt_in(evt_in), .flags(flags)
  );

  es_status #(.N(N)) u_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flags(flags),
    .es_mask(es_mask), .stat_rd(stat_rd), .pin_mode(pin_mode),
    .isr_es(isr_es), .isr_sec(isr_sec), .irq(irq), .sec_out(sec_out)
  );
endmodule

// File: rtl/es_monitor_chk.sv
module es_monitor_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         stat_rd,
  input logic [N-1:0] evt_in,
  input logic [N-1:0] flags,
  input logic         isr_es,
  input logic         isr_sec,
  input logic         irq
);
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_flags_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags == $past(evt_in));

  assert_es_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_es) |-> $past(tick));

  assert_sec_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> isr_sec);

  assert_sec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_sec && !stat_rd) |=> isr_sec);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_es) |-> irq);
endmodule

bind es_monitor es_monitor_chk #(.N(es_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .stat_rd(stat_rd),
  .evt_in(evt_in), .flags(flags), .isr_es(isr_es),
  .isr_sec(isr_sec), .irq(irq)
);

// File: tb/es_monitor_test.sv
module es_monitor_test;
  localparam int CNT_W = 16;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ce = 1'b0;
  logic [CNT_W-1:0] tick_limit = 16'd5;
  logic [N-1:0] evt_in = '0;
  logic [N-1:0] es_mask = '0;
  logic [1:0] pin_mode = 2'd1;
  logic stat_rd = 1'b0;
  logic isr_es, isr_sec, irq, sec_out;
  logic [N-1:0] flags;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [CNT_W-1:0] m_cnt;
  logic m_tick, m_es, m_sec, m_tog;
  logic [N-1:0] m_flags;

  always #4 clk = ~clk;

  es_monitor #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .tick_limit(tick_limit),
    .evt_in(evt_in), .es_mask(es_mask), .pin_mode(pin_mode),
    .stat_rd(stat_rd), .isr_es(isr_es), .isr_sec(isr_sec), .irq(irq),
    .sec_out(sec_out), .flags(flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_pin(input logic [1:0] mode, input logic tk, input logic tg);
    case (mode)
      2'd1: return tk;
      2'd2: return ~tk;
      2'd3: return tg;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_tick = 0; m_es = 0; m_sec = 0; m_tog = 0; m_flags = '0;
  endtask

  task automatic model_step();
    logic nt;
    logic hit;
    nt  = ref_ce && (m_cnt >= tick_limit);
    hit = |(m_flags & es_mask);
    m_es  = (m_es  & ~stat_rd) | (m_tick & hit);
    m_sec = (m_sec & ~stat_rd) | m_tick;
    if (m_tick) begin
      m_tog = ~m_tog;
      m_flags = evt_in;
    end else begin
      m_flags = m_flags | evt_in;
    end
    if (nt) m_cnt = '0;
    else if (ref_ce) m_cnt = m_cnt + 1'b1;
    m_tick = nt;
  endtask

  task automatic compare_all(input string tag);
    check({"R3 flags ", tag}, 32'(flags), 32'(m_flags));
    check({"R4 isr_es ", tag}, 32'(isr_es), 32'(m_es));
    check({"R5 R2 isr_sec ", tag}, 32'(isr_sec), 32'(m_sec));
    check({"R6 sec_out ", tag}, 32'(sec_out), 32'(exp_pin(pin_mode, m_tick, m_tog)));
    check({"R8 irq ", tag}, 32'(irq), 32'(m_es | m_sec));
  endtask

  task automatic run(input int cycles, input int ce_pct, input int rd_pct,
                     input logic [N-1:0] evt_bias, input logic [N-1:0] hold,
                     input string tag);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all(tag);
      ref_ce  = ($urandom % 100) < ce_pct;
      stat_rd = ($urandom % 100) < rd_pct;
      evt_in  = (($urandom % 16) == 0 ? N'($urandom) & evt_bias : '0) | hold;
      @(posedge clk);
      #1;
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset isr_es", 32'(isr_es), 0);
    check("R1 reset isr_sec", 32'(isr_sec), 0);
    check("R1 reset irq", 32'(irq), 0);
    check("R1 reset flags", 32'(flags), 0);
    check("R1 reset sec_out", 32'(sec_out), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    model_step();

    // R2: steady enable, exact tick spacing
    tick_limit = 16'd4; es_mask = 8'hFF; pin_mode = 2'd1;
    run(60, 100, 0, 8'h00, 8'h00, "steady");
    // R2: gated enable
    run(300, 40, 10, 8'hFF, 8'h00, "gated");
    // R4: all masked, events ignored
    es_mask = 8'h00; pin_mode = 2'd2;
    run(400, 100, 20, 8'hFF, 8'h00, "masked");
    // R4: partial mask
    es_mask = 8'h41; pin_mode = 2'd3;
    run(1500, 70, 15, 8'hFF, 8'h00, "partial");
    // R9: loss of signal held across boundaries
    es_mask = 8'h10; tick_limit = 16'd6; pin_mode = 2'd0;
    run(200, 100, 50, 8'h00, 8'h10, "held_level");
    // R7: read every cycle, set must survive coinciding read
    es_mask = 8'hFF; tick_limit = 16'd2; pin_mode = 2'd1;
    run(100, 100, 100, 8'hFF, 8'h00, "read_always");
    // mixed random with changing limit
    for (int p = 0; p < 6; p++) begin
      tick_limit = 16'($urandom % 20);
      es_mask = N'($urandom);
      pin_mode = 2'($urandom);
      run(500, 80, 12, 8'hFF, 8'h00, "random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule